// File: doc/BRIEF.md
# Receive Lane Synchronization Monitor

This block decides whether a serial receive lane can be trusted. It sits after the word aligner and the 8B/10B decoder. For each received 10-bit code group it gets a strobe, the raw code group and an error flag. The error flag is raised by the decoder when it sees a code violation or a disparity error. The block drives a single registered level that says whether the lane is in sync.

Starting from the unsynchronized state, the block looks for a long, unbroken run of comma characters (K28.5, in either disparity). One error during that run throws away the progress made so far. Once the lane is in sync, occasional errors are tolerated. The lane drops back only when errors cluster: the third one arrives before a long stretch of clean code groups has cleared the earlier ones.

Top module: `lane_sync_monitor`

## Requirements
- R1: Starting from loss of sync, the status goes high in the cycle after the 127th K28.5 code group of a run that contains no invalid group. After 126 such commas it is still low.
- R2: Both K28.5 encodings count as commas: 10'b0101111100 (0x17C) and 10'b1010000011 (0x283).
- R3: An invalid group that arrives before sync is reached resets the comma count to zero. A fresh run of 127 commas is then needed.
- R4: During acquisition, valid code groups that are neither comma encoding and carry no error leave the comma count unchanged.
- R5: While in sync, the status goes low in the cycle after the third invalid group, when each gap between consecutive invalid groups holds at most 254 valid groups.
- R6: While in sync, 255 consecutive valid groups after an invalid group clear the error history. Invalid groups spaced 255 valid groups apart therefore never cause loss of sync.
- R7: A synchronous active-high reset drives the status low and clears all counts. After reset, a full run of 127 commas is needed again.
- R8: Cycles with the valid strobe low are ignored, whatever the code group and error inputs carry.
- R9: After loss of sync, the status stays low until a new run of 127 clean commas is complete.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive parallel clock |
| rst | input | 1 | Synchronous reset, active high |
| cg_valid | input | 1 | A code group is present this cycle |
| cg_data | input | 10 | Raw 10-bit code group from the aligner |
| cg_invalid | input | 1 | Decoder reports a code or disparity error for this group |
| sync_o | output | 1 | High while the lane is synchronized, registered |

## Verification
Acquisition is driven with comma runs that stop one short of the threshold and runs that land exactly on it. It is also driven with runs broken by an error at comma 126, and with runs that mix both disparities and neutral data groups. Together these separate a counter that restarts on an error from one that only pauses, and show whether non-comma groups are ignored or wrongly counted. In sync, error pairs spaced 254 and 255 valid groups apart pin the clearing window to its exact length. Idle cycles that carry the error flag show whether the strobe truly gates every count.

// File: rtl/lane_sync_pkg.sv
package lane_sync_pkg;

  localparam int CG_W = 10;

  // Comma, one running disparity; the other disparity is its bitwise complement
  localparam logic [CG_W-1:0] COMMA_RDM = 10'b0101111100;

  typedef enum logic {
    ST_LOS  = 1'b0,
    ST_SYNC = 1'b1
  } sync_state_e;

endpackage

// File: rtl/lane_sync_comma.sv
module lane_sync_comma
  import lane_sync_pkg::*;
(
  input  logic [CG_W-1:0] code,
  output logic            is_comma
);

  localparam int N_PAT = 2;

  logic [N_PAT-1:0] hit;

  for (genvar p = 0; p < N_PAT; p++) begin : g_pat
    localparam logic [CG_W-1:0] PAT = (p == 0) ? COMMA_RDM : ~COMMA_RDM;
    assign hit[p] = (code == PAT);
  end

  assign is_comma = |hit;

endmodule

// File: rtl/lane_sync_acq.sv
module lane_sync_acq #(
  parameter int TARGET = 127
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic restart,
  input  logic step,
  output logic done
);

  localparam int CW = $clog2(TARGET + 1);

  logic [CW-1:0] cnt;

  assign done = step && (cnt == CW'(TARGET - 1));

  always_ff @(posedge clk) begin
    if (rst || clear || restart || done) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_ACQ_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(TARGET)); // R1

  AST_ACQ_RESTART: assert property (@(posedge clk) disable iff (rst)
    restart |=> cnt == '0); // R3

endmodule

// File: rtl/lane_sync_errmon.sv
module lane_sync_errmon #(
  parameter int LIMIT = 3,
  parameter int RUN   = 255
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic valid,
  input  logic bad,
  output logic lose
);

  localparam int EW = $clog2(LIMIT + 1);
  localparam int RW = $clog2(RUN + 1);

  logic [EW-1:0] err;
  logic [RW-1:0] run;
  logic          run_full;

  assign lose     = active && valid && bad && (err == EW'(LIMIT - 1));
  assign run_full = (run == RW'(RUN - 1));

  always_ff @(posedge clk) begin
    if (rst || !active || lose) begin
      err <= '0;
      run <= '0;
    end else if (valid) begin
      if (bad) begin
        err <= err + 1'b1;
        run <= '0;
      end else if (err != '0) begin
        if (run_full) begin
          err <= '0;
          run <= '0;
        end else begin
          run <= run + 1'b1;
        end
      end
    end
  end

  AST_ERR_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
    err < EW'(LIMIT)); // R5

  AST_RUN_CLEARS_ERR: assert property (@(posedge clk) disable iff (rst)
    (active && valid && !bad && err != '0 && run_full) |=> err == '0); // R6

endmodule

// File: rtl/lane_sync_monitor.sv
module lane_sync_monitor
  import lane_sync_pkg::*;
#(
  parameter int ACQ_COMMAS = 127,
  parameter int ERR_LIMIT  = 3,
  parameter int CLEAR_RUN  = 255
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cg_valid,
  input  logic [CG_W-1:0] cg_data,
  input  logic            cg_invalid,
  output logic            sync_o
);

  sync_state_e state;
  logic        is_comma;
  logic        in_los;
  logic        acq_step;
  logic        acq_restart;
  logic        acq_done;
  logic        lose;

  lane_sync_comma u_comma (
    .code     (cg_data),
    .is_comma (is_comma)
  );

  assign in_los      = (state == ST_LOS);
  assign acq_step    = in_los && cg_valid && !cg_invalid && is_comma;
  assign acq_restart = in_los && cg_valid && cg_invalid;

  lane_sync_acq #(.TARGET(ACQ_COMMAS)) u_acq (
    .clk     (clk),
    .rst     (rst),
    .clear   (!in_los),
    .restart (acq_restart),
    .step    (acq_step),
    .done    (acq_done)
  );

  lane_sync_errmon #(.LIMIT(ERR_LIMIT), .RUN(CLEAR_RUN)) u_err (
    .clk    (clk),
    .rst    (rst),
    .active (!in_los),
    .valid  (cg_valid),
    .bad    (cg_invalid),
    .lose   (lose)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_LOS;
    end else begin
      case (state)
        ST_LOS:  if (acq_done) state <= ST_SYNC;
        ST_SYNC: if (lose)     state <= ST_LOS;
        default: state <= ST_LOS;
      endcase
    end
  end

  assign sync_o = (state == ST_SYNC);

  AST_RISE_ON_COMMA: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_o) |-> $past(cg_valid && !cg_invalid && is_comma)); // R1

  AST_FALL_ON_ERROR: assert property (@(posedge clk) disable iff (rst)
    $fell(sync_o) |-> ($past(rst) || $past(cg_valid && cg_invalid))); // R5

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !cg_valid |=> $stable(sync_o)); // R8

  AST_RESET_LOS: assert property (@(posedge clk)
    rst |=> !sync_o); // R7

endmodule

// File: tb/test_lane_sync_monitor.sv
module test_lane_sync_monitor;

  localparam logic [9:0] CA = 10'b0101111100;
  localparam logic [9:0] CB = 10'b1010000011;
  localparam logic [9:0] DATA = 10'b1001110100;

  // kinds: 0 comma A, 1 comma B, 2 clean data, 3 invalid, 4 idle carrying error
  typedef struct packed {
    logic [2:0] kind;
    logic [8:0] n;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 9'd125, 1'b0, 4'd1},  // R1 partial run
    '{3'd3, 9'd1,   1'b0, 4'd3},  // R3 error at comma 126
    '{3'd1, 9'd126, 1'b0, 4'd3},  // R3 restarted count, 126 only
    '{3'd2, 9'd5,   1'b0, 4'd4},  // R4 neutral data
    '{3'd4, 9'd3,   1'b0, 4'd8},  // R8 idle with error flag
    '{3'd0, 9'd1,   1'b1, 4'd2},  // R2 mixed disparity reaches 127
    '{3'd3, 9'd1,   1'b1, 4'd5},  // R5 first error
    '{3'd2, 9'd254, 1'b1, 4'd5},
    '{3'd3, 9'd1,   1'b1, 4'd5},  // second error
    '{3'd2, 9'd254, 1'b1, 4'd5},
    '{3'd3, 9'd1,   1'b0, 4'd5},  // third error -> loss
    '{3'd0, 9'd126, 1'b0, 4'd9},  // R9 not yet
    '{3'd0, 9'd1,   1'b1, 4'd9},  // R9 reacquired
    '{3'd3, 9'd1,   1'b1, 4'd6},  // R6 spaced 255
    '{3'd2, 9'd255, 1'b1, 4'd6},
    '{3'd3, 9'd1,   1'b1, 4'd6},
    '{3'd2, 9'd255, 1'b1, 4'd6},
    '{3'd3, 9'd1,   1'b1, 4'd6},
    '{3'd4, 9'd10,  1'b1, 4'd8},  // R8 idle errors in sync
    '{3'd3, 9'd1,   1'b1, 4'd8},
    '{3'd3, 9'd1,   1'b0, 4'd5}   // back-to-back third error
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cg_valid = 1'b0;
  logic [9:0] cg_data = '0;
  logic       cg_invalid = 1'b0;
  logic       sync_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lane_sync_monitor i_lane_sync_monitor (
    .clk        (clk),
    .rst        (rst),
    .cg_valid   (cg_valid),
    .cg_data    (cg_data),
    .cg_invalid (cg_invalid),
    .sync_o     (sync_o)
  );

  task automatic send(input logic [2:0] kind, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cg_valid   = (kind != 3'd4);
      cg_invalid = (kind == 3'd3) || (kind == 3'd4);
      cg_data    = (kind == 3'd1) ? CB : (kind == 3'd2) ? DATA : CA;
    end
    @(negedge clk);
    cg_valid   = 1'b0;
    cg_invalid = 1'b0;
    cg_data    = DATA;
  endtask

  task automatic check(input logic exp, input int req);
    checks++;
    if (sync_o !== exp) begin
      errors++;
      $display("FAIL R%0d sync_o actual %b expected %b", req, sync_o, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(1'b0, 7); // R7 reset state

    for (int v = 0; v < NV; v++) begin
      send(VEC[v].kind, int'(VEC[v].n));
      check(VEC[v].exp, int'(VEC[v].req));
    end

    // R7 reset while synchronized, then a full new run is needed
    send(3'd0, 127);
    check(1'b1, 1); // R1 exact 127
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(1'b0, 7); // R7
    send(3'd1, 126);
    check(1'b0, 7); // R7 count cleared
    send(3'd1, 1);
    check(1'b1, 7);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule